// File: doc/BRIEF.md
# Worst-Case Coupling Fault Injector

This block sits inline on a 16-bit link between two routers and deliberately corrupts data the way capacitive coupling between neighbouring wires would in the worst case. On every valid transfer it compares the incoming word with the last word that was transferred. For each bit it then looks at the bit itself, the victim, and at its aggressors: the neighbours up to two lines away on either side. When every aggressor switches in one direction and the victim matches one of four worst-case patterns, the victim's value is inverted on the forwarded bus.

The four fault conditions are glitch-high, glitch-low, slow rise and slow fall. Each one is switched on or off by its own parameter, so a test can inject faults for a chosen subset. The block adds no latency: the corrupted word leaves in the same cycle it arrives. Two counters record how many words were transferred and how many bit errors were injected, so a test can compute the fault rate on the link.

Top module: `xtalk_injector`

## Requirements
- R1: `out_valid` equals `in_valid` in the same cycle, with no register in the data path.
- R2: While `in_valid` is low, `out_data` equals `in_data`, and neither counter nor the reference word changes.
- R3: The reference word is the data of the most recent cycle with `in_valid` high. It is all zeros after reset. A valid word equal to the reference word is forwarded unchanged.
- R4: Glitch-high: if the victim is 0 in both the reference and the current word, and every aggressor goes 0 to 1, the victim is forwarded as 1.
- R5: Glitch-low: if the victim is 1 in both words, and every aggressor goes 1 to 0, the victim is forwarded as 0.
- R6: Slow rise: if the victim goes 0 to 1 while every aggressor goes 1 to 0, the victim is forwarded as 0.
- R7: Slow fall: if the victim goes 1 to 0 while every aggressor goes 0 to 1, the victim is forwarded as 1.
- R8: The aggressors of bit i are the existing bits i-2, i-1, i+1 and i+2 within 0..15. Bit 0 therefore uses bits 1 and 2, and bit 15 uses bits 13 and 14. Every aggressor that exists must switch for a fault to occur.
- R9: If any aggressor of a victim does not switch in the direction its condition requires, that victim is forwarded unchanged. Each victim is judged only on the incoming and reference words.
- R10: Parameters `EN_GLITCH_HI`, `EN_GLITCH_LO`, `EN_SLOW_RISE` and `EN_SLOW_FALL` (1 = active) each enable one condition. A disabled condition never corrupts a bit.
- R11: `xfer_count` is 0 after reset and increases by one in the cycle after each valid transfer.
- R12: `fault_count` is 0 after reset and increases, in the cycle after each valid transfer, by the number of bits inverted in that transfer.
- R13: During reset both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream word is valid this cycle |
| in_data | input | 16 | Upstream word |
| out_valid | output | 1 | Downstream valid, equal to `in_valid` |
| out_data | output | 16 | Downstream word, possibly with inverted victims |
| xfer_count | output | 16 | Number of valid transfers, wraps |
| fault_count | output | 16 | Number of injected bit errors, wraps |

## Verification
Directed word pairs build each of the four patterns around a middle victim and at both bus edges. These show whether the condition decode and the trimmed edge windows are correct. Near-miss pairs, with one aggressor held still, show whether the block demands that all aggressors switch. Idle cycles with changing data, followed by a valid word, show whether the reference word is only updated by transfers. Constructed and random sequences, some with gaps in valid, are run on two instances with different enable sets. These separate the per-condition enables and check that the error counter adds several flips from one word correctly.

// File: rtl/xtalk_pkg.sv
package xtalk_pkg;

  // Index of each fault condition in a condition vector
  typedef enum logic [1:0] {
    XT_GLITCH_HI  = 2'd0,
    XT_GLITCH_LO  = 2'd1,
    XT_SLOW_RISE  = 2'd2,
    XT_SLOW_FALL  = 2'd3
  } xt_cond_e;

  localparam int XT_MAX_W = 64;

  // Population count over a zero-extended vector
  function automatic logic [6:0] xt_ones(input logic [XT_MAX_W-1:0] v);
    logic [6:0] n;
    n = '0;
    for (int i = 0; i < XT_MAX_W; i++) n = n + {6'd0, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/xtalk_edge_track.sv
module xtalk_edge_track #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] cur,
  output logic [W-1:0] prev,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  always_ff @(posedge clk) begin
    if (!rst_n)    prev <= '0;
    else if (take) prev <= cur;
  end

  assign rise = ~prev &  cur;
  assign fall =  prev & ~cur;

endmodule

// File: rtl/xtalk_window_match.sv
module xtalk_window_match #(
  parameter int W            = 16,
  parameter int RADIUS       = 2,
  parameter bit EN_GLITCH_HI = 1'b1,
  parameter bit EN_GLITCH_LO = 1'b1,
  parameter bit EN_SLOW_RISE = 1'b1,
  parameter bit EN_SLOW_FALL = 1'b1
) (
  input  logic [W-1:0] prev,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  output logic [W-1:0] flip
);

  // Aggressor set of victim v: neighbours within RADIUS that exist
  function automatic logic [W-1:0] nbr_mask(input int v);
    logic [W-1:0] m;
    m = '0;
    for (int j = 0; j < W; j++)
      if (j != v && j >= v - RADIUS && j <= v + RADIUS) m[j] = 1'b1;
    return m;
  endfunction

  for (genvar v = 0; v < W; v++) begin : g_victim
    localparam logic [W-1:0] NM = nbr_mask(v);
    logic all_up, all_dn, hold_lo, hold_hi;
    logic [3:0] cond;

    assign all_up  = &(rise | ~NM);
    assign all_dn  = &(fall | ~NM);
    assign hold_lo = ~prev[v] & ~cur[v];
    assign hold_hi =  prev[v] &  cur[v];

    assign cond[xtalk_pkg::XT_GLITCH_HI] = EN_GLITCH_HI & hold_lo & all_up;
    assign cond[xtalk_pkg::XT_GLITCH_LO] = EN_GLITCH_LO & hold_hi & all_dn;
    assign cond[xtalk_pkg::XT_SLOW_RISE] = EN_SLOW_RISE & rise[v] & all_dn;
    assign cond[xtalk_pkg::XT_SLOW_FALL] = EN_SLOW_FALL & fall[v] & all_up;

    assign flip[v] = |cond;
  end

endmodule

// File: rtl/xtalk_counters.sv
module xtalk_counters #(
  parameter int W  = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [W-1:0]  flips,
  output logic [CW-1:0] xfer_count,
  output logic [CW-1:0] fault_count
);

  logic [6:0] n_flips;
  assign n_flips = xtalk_pkg::xt_ones({{(xtalk_pkg::XT_MAX_W-W){1'b0}}, flips});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_count  <= '0;
      fault_count <= '0;
    end else if (take) begin
      xfer_count  <= xfer_count + CW'(1);
      fault_count <= fault_count + CW'(n_flips);
    end
  end

endmodule

// File: rtl/xtalk_injector.sv
module xtalk_injector #(
  parameter int W            = 16,
  parameter int RADIUS       = 2,
  parameter int CW           = 16,
  parameter bit EN_GLITCH_HI = 1'b1,
  parameter bit EN_GLITCH_LO = 1'b1,
  parameter bit EN_SLOW_RISE = 1'b1,
  parameter bit EN_SLOW_FALL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] xfer_count,
  output logic [CW-1:0] fault_count
);

  // Named internal events, visible to the bound checker
  logic [W-1:0] prev_word;
  logic [W-1:0] rise_vec, fall_vec;
  logic [W-1:0] match_vec;
  logic [W-1:0] flip_vec;

  xtalk_edge_track #(.W(W)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (in_valid),
    .cur   (in_data),
    .prev  (prev_word),
    .rise  (rise_vec),
    .fall  (fall_vec)
  );

  xtalk_window_match #(
    .W(W), .RADIUS(RADIUS),
    .EN_GLITCH_HI(EN_GLITCH_HI), .EN_GLITCH_LO(EN_GLITCH_LO),
    .EN_SLOW_RISE(EN_SLOW_RISE), .EN_SLOW_FALL(EN_SLOW_FALL)
  ) u_match (
    .prev (prev_word),
    .cur  (in_data),
    .rise (rise_vec),
    .fall (fall_vec),
    .flip (match_vec)
  );

  assign flip_vec  = in_valid ? match_vec : '0;
  assign out_valid = in_valid;
  assign out_data  = in_data ^ flip_vec;

  xtalk_counters #(.W(W), .CW(CW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (in_valid),
    .flips       (flip_vec),
    .xfer_count  (xfer_count),
    .fault_count (fault_count)
  );

endmodule

// File: rtl/xtalk_injector_chk.sv
module xtalk_injector_chk #(
  parameter int W  = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  in_data,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic [CW-1:0] xfer_count,
  input logic [CW-1:0] fault_count,
  input logic [W-1:0]  prev_word
);

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == in_valid);

  p_idle_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> out_data == in_data);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(xfer_count) && $stable(fault_count) && $stable(prev_word));

  p_ref_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> prev_word == $past(in_data));

  p_quiet_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == prev_word) |-> out_data == in_data);

  p_xfer_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> xfer_count == $past(xfer_count) + CW'(1));

  p_fault_sum_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> fault_count == $past(fault_count) + CW'($countones($past(in_data ^ out_data))));

  p_reset_zero_r13: assert property (@(posedge clk)
    !rst_n |=> xfer_count == '0 && fault_count == '0);

endmodule

bind xtalk_injector xtalk_injector_chk #(.W(W), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_data     (in_data),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .xfer_count  (xfer_count),
  .fault_count (fault_count),
  .prev_word   (prev_word)
);

// File: tb/xtalk_injector_test.sv
module xtalk_injector_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        out_valid, out_valid2;
  logic [15:0] out_data, out_data2;
  logic [15:0] xfer_count, fault_count, xfer_count2, fault_count2;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Bench model state
  logic [15:0] m_prev = '0;
  int m_xfer = 0, m_fault = 0, m_fault2 = 0;

  always #4 clk = ~clk;

  xtalk_injector uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .xfer_count(xfer_count), .fault_count(fault_count));

  // Second instance: glitch-high and slow-rise switched off (R10)
  xtalk_injector #(.EN_GLITCH_HI(1'b0), .EN_SLOW_RISE(1'b0)) uut2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid2), .out_data(out_data2),
    .xfer_count(xfer_count2), .fault_count(fault_count2));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: counts switching neighbours by distance
  function automatic logic [15:0] model_flip(input logic [15:0] p, input logic [15:0] c,
                                             input bit e_hi, input bit e_lo, input bit e_rs, input bit e_fl,
                                             output logic [3:0] seen);
    logic [15:0] f;
    int nn, nu, nd, j;
    bit up_all, dn_all, p0, c0;
    f = '0;
    seen = '0;
    for (int i = 0; i < 16; i++) begin
      nn = 0; nu = 0; nd = 0;
      for (int d = -2; d <= 2; d++) begin
        j = i + d;
        if (d != 0 && j >= 0 && j <= 15) begin
          nn++;
          if (p[j] == 1'b0 && c[j] == 1'b1) nu++;
          if (p[j] == 1'b1 && c[j] == 1'b0) nd++;
        end
      end
      up_all = (nu == nn);
      dn_all = (nd == nn);
      p0 = p[i]; c0 = c[i];
      if (e_hi && !p0 && !c0 && up_all) begin f[i] = 1'b1; seen[0] = 1'b1; end
      if (e_lo &&  p0 &&  c0 && dn_all) begin f[i] = 1'b1; seen[1] = 1'b1; end
      if (e_rs && !p0 &&  c0 && dn_all) begin f[i] = 1'b1; seen[2] = 1'b1; end
      if (e_fl &&  p0 && !c0 && up_all) begin f[i] = 1'b1; seen[3] = 1'b1; end
    end
    return f;
  endfunction

  task automatic step(input bit v, input logic [15:0] d, input string tag);
    logic [15:0] f1, f2, e1, e2;
    logic [3:0] s1, s2;
    string t;
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    #1;
    f1 = v ? model_flip(m_prev, d, 1, 1, 1, 1, s1) : 16'h0;
    f2 = v ? model_flip(m_prev, d, 0, 1, 0, 1, s2) : 16'h0;
    e1 = d ^ f1;
    e2 = d ^ f2;
    t = tag;
    if (t == "") begin
      if (!v)         t = "R2";
      else if (s1[0]) t = "R4";
      else if (s1[1]) t = "R5";
      else if (s1[2]) t = "R6";
      else if (s1[3]) t = "R7";
      else            t = "R9";
    end
    chk(out_valid == v && out_valid2 == v, "R1 valid", {31'd0, out_valid}, {31'd0, v});
    chk(out_data == e1, {t, " data"}, {16'd0, out_data}, {16'd0, e1});
    chk(out_data2 == e2, "R10 data (partial enables)", {16'd0, out_data2}, {16'd0, e2});
    chk(xfer_count == 16'(m_xfer) && xfer_count2 == 16'(m_xfer), "R11 xfer_count", {16'd0, xfer_count}, m_xfer);
    chk(fault_count == 16'(m_fault), "R12 fault_count", {16'd0, fault_count}, m_fault);
    chk(fault_count2 == 16'(m_fault2), "R12 fault_count (partial enables)", {16'd0, fault_count2}, m_fault2);
    if (v) begin
      m_prev = d;
      m_xfer++;
      m_fault  += $countones(f1);
      m_fault2 += $countones(f2);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    repeat (3) @(posedge clk);
    #1;
    // R13: counters read zero during reset
    chk(xfer_count == 0 && fault_count == 0, "R13 reset counters", {xfer_count, fault_count}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 and R8: reference starts at zero; bit 0 glitches high from bits 1,2 rising
    step(1, 16'h0006, "R8");
    step(1, 16'h0000, "");
    // R4: middle victim 7, aggressors 5,6,8,9 rise
    step(1, 16'h0360, "R4");
    step(1, 16'h03E0, "");
    // R5: victim 7 held high, aggressors fall
    step(1, 16'h0080, "R5");
    // R7: victim falls, aggressors rise
    step(1, 16'h0360, "R7");
    // R6: victim rises, aggressors fall
    step(1, 16'h0080, "R6");
    // R9: aggressor 5 stays low, so no fault on victim 7
    step(1, 16'h0340, "R9");
    step(1, 16'h0000, "");
    // R8: top edge victim 15 with aggressors 13,14
    step(1, 16'h6000, "R8");
    // R2: idle cycles with changing data
    step(0, 16'hFFFF, "R2");
    step(0, 16'h1FFF, "R2");
    // R3: reference still 0x6000, so same word passes untouched
    step(1, 16'h6000, "R3");

    // Constructed pairs: random victim and condition, other bits random
    for (int k = 0; k < 400; k++) begin
      int vb, cond;
      logic [15:0] a, b, nm;
      vb = $urandom_range(0, 15);
      cond = $urandom_range(0, 3);
      nm = '0;
      for (int d = -2; d <= 2; d++)
        if (d != 0 && vb + d >= 0 && vb + d <= 15) nm[vb + d] = 1'b1;
      a = 16'($urandom);
      b = 16'($urandom);
      case (cond)
        0: begin a = a & ~nm; b = b | nm; a[vb] = 0; b[vb] = 0; end
        1: begin a = a | nm; b = b & ~nm; a[vb] = 1; b[vb] = 1; end
        2: begin a = a | nm; b = b & ~nm; a[vb] = 0; b[vb] = 1; end
        default: begin a = a & ~nm; b = b | nm; a[vb] = 1; b[vb] = 0; end
      endcase
      if (k % 5 == 4) b[vb + ((vb < 8) ? 1 : -1)] = a[vb + ((vb < 8) ? 1 : -1)]; // R9 near miss
      step(1, a, "");
      if (k % 7 == 3) step(0, ~b, "R2");
      step(1, b, "");
    end

    // Unstructured traffic with gaps
    for (int k = 0; k < 600; k++)
      step(($urandom_range(0, 3) != 0), 16'($urandom), "");

    step(0, 16'h0000, "R11");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule